// File: doc/BRIEF.md
# Per-CPU Interrupt Interface

This block is the front end that one processor core sees of a multi-core interrupt controller. It keeps a private view of 256 interrupt ids: an enable bit and an in-service (active) bit per id. Ids 0 to 31 are private to the core and arrive as raw lines, each conditioned by a programmable trigger mode. Ids 32 to 255 are shared and arrive as an already-processed pending vector from the distributor. The interface raises an interrupt request to its core whenever an enabled, pending and not-yet-active id exists, and it names the best one through a readable claim register.

Software drives the block through a 4 KB register window. Enabling, disabling and finishing an interrupt are each done by writing the id number to a dedicated offset, so no read-modify-write is needed. Reading the claim register hands over the lowest-numbered candidate and marks it in service until software writes the same number to the completion offset. A single packed write emits a software-generated inter-processor interrupt, carrying a small id and a target mask of cores, toward the distributor.

Top module: `cpu_irq_port`

## Requirements
- R1: After reset irq_o, sgi_valid_o and bus_rdata_o are 0, the control word reads 0, both trigger words read 0 and no id is enabled or active.
- R2: Bit 0 of the word at offset 0x000 turns the interface on and reads back there with all other bits 0; while it is 0, irq_o stays low and a claim read returns 0x3FF without making any id active.
- R3: Writing an id in bits [7:0] to offset 0x0A0 enables it and to offset 0x0A4 disables it; such a write with any bit above bit 7 set changes nothing.
- R4: A read of offset 0x06C returns, on bus_rdata_o in the cycle after the read strobe, the lowest-numbered id that is enabled, pending and not active, zero-extended to 32 bits.
- R5: The id returned by a claim read becomes active: it is neither offered again nor counted toward irq_o until its number is written to offset 0x0B4.
- R6: A claim read with no candidate returns 0x3FF.
- R7: irq_o is high, without a clock of delay, exactly while the interface is on and at least one candidate id exists.
- R8: A write to offset 0x060 gives a one-cycle sgi_valid_o pulse in the next cycle with sgi_id_o equal to write bits [3:0] and sgi_targets_o equal to write bits [15:8].
- R9: Trigger modes of the private ids live in two read/write words, offset 0x014 for ids 0-15 and offset 0x018 for ids 16-31, two bits per id at bits [2n+1:2n] with n the id's place in its word; code 0 is level high, 1 level low, 2 rising edge, 3 falling edge.
- R10: A private id in an edge mode latches a detected edge and stays pending after the line settles, until the id is returned by a claim read; level-mode private ids follow the line with the chosen polarity.
- R11: Shared ids 32-255 are pending while bit (id-32) of shared_pend_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 12 | Byte offset inside the window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| shared_pend_i | input | 224 | Pending vector for ids 32-255 from the distributor |
| priv_line_i | input | 32 | Raw lines of private ids 0-31 |
| irq_o | output | 1 | Interrupt request to the core |
| sgi_valid_o | output | 1 | Inter-processor interrupt send pulse |
| sgi_id_o | output | 4 | Id of the inter-processor interrupt |
| sgi_targets_o | output | 8 | Target core mask |

## Verification
The bench puts a private and two shared ids pending together and claims them one by one, so a picker that favoured high ids or ignored the private half would return them out of order. It reads the claim register while the interface is off and then again after turning it on; a design that activated the id on the ignored read would hand back 0x3FF the second time. Edge-mode ids are pulsed for one cycle and then claimed twice, so a design that lost the edge would never raise the request and one that failed to clear the latch would offer the id a second time. An enable write with stray high bits is followed by a claim read, which exposes a decoder that looks only at the low byte.

// File: rtl/cirq_pkg.sv
package cirq_pkg;

    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_TRIG  = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_SGI   = 12'h060;
    localparam logic [ADDR_W-1:0] OFS_CLAIM = 12'h06C;
    localparam logic [ADDR_W-1:0] OFS_EN    = 12'h0A0;
    localparam logic [ADDR_W-1:0] OFS_DIS   = 12'h0A4;
    localparam logic [ADDR_W-1:0] OFS_DONE  = 12'h0B4;

    localparam logic [31:0] NO_CLAIM = 32'h0000_03FF;

    typedef enum logic [1:0] {
        TRIG_LVL_HI = 2'd0,
        TRIG_LVL_LO = 2'd1,
        TRIG_RISE   = 2'd2,
        TRIG_FALL   = 2'd3
    } trig_e;

    function automatic logic trig_is_edge(input trig_e m);
        return (m == TRIG_RISE) || (m == TRIG_FALL);
    endfunction

endpackage

// File: rtl/cirq_priv_sense.sv
module cirq_priv_sense
    import cirq_pkg::*;
#(
    parameter int PRIV_IDS = 32,
    localparam int PID_W   = $clog2(PRIV_IDS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [PRIV_IDS-1:0]   line_i,
    input  logic [2*PRIV_IDS-1:0] cfg_i,
    input  logic                  ack_valid_i,
    input  logic [PID_W-1:0]      ack_id_i,
    output logic [PRIV_IDS-1:0]   pend_o
);

    for (genvar i = 0; i < PRIV_IDS; i++) begin : g_line
        trig_e mode;
        logic  prev_q;
        logic  edge_q;
        logic  rise_w;
        logic  fall_w;
        logic  hit_w;

        assign mode   = trig_e'(cfg_i[2*i +: 2]);
        assign rise_w = line_i[i] & ~prev_q;
        assign fall_w = ~line_i[i] & prev_q;
        assign hit_w  = (mode == TRIG_RISE) ? rise_w :
                        (mode == TRIG_FALL) ? fall_w : 1'b0;

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q <= 1'b0;
                edge_q <= 1'b0;
            end else begin
                prev_q <= line_i[i];
                if (!trig_is_edge(mode))
                    edge_q <= 1'b0;
                else if (hit_w)
                    edge_q <= 1'b1;
                else if (ack_valid_i && ack_id_i == PID_W'(i))
                    edge_q <= 1'b0;
            end
        end

        always_comb begin
            unique case (mode)
                TRIG_LVL_HI: pend_o[i] = line_i[i];
                TRIG_LVL_LO: pend_o[i] = ~line_i[i];
                default:     pend_o[i] = edge_q;
            endcase
        end

        // R10: a detected edge in an edge mode is held as pending
        assert_edge_latched_R10: assert property (@(posedge clk) disable iff (rst)
            (trig_is_edge(mode) && hit_w) |=> edge_q);
    end

endmodule

// File: rtl/cirq_pick.sv
module cirq_pick #(
    parameter int NUM_IDS = 256,
    localparam int ID_W   = $clog2(NUM_IDS)
) (
    input  logic [NUM_IDS-1:0] cand_i,
    output logic               found_o,
    output logic [ID_W-1:0]    id_o
);

    always_comb begin
        found_o = 1'b0;
        id_o    = '0;
        for (int i = NUM_IDS - 1; i >= 0; i--) begin
            if (cand_i[i]) begin
                found_o = 1'b1;
                id_o    = ID_W'(i);
            end
        end
    end

endmodule

// File: rtl/cpu_irq_port.sv
module cpu_irq_port
    import cirq_pkg::*;
#(
    parameter int NUM_IDS  = 256,
    parameter int PRIV_IDS = 32,
    parameter int NUM_CPUS = 8,
    parameter int SGI_ID_W = 4,
    localparam int SHARED  = NUM_IDS - PRIV_IDS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr_i,
    input  logic                bus_rd_i,
    input  logic [11:0]         bus_addr_i,
    input  logic [31:0]         bus_wdata_i,
    output logic [31:0]         bus_rdata_o,
    input  logic [SHARED-1:0]   shared_pend_i,
    input  logic [PRIV_IDS-1:0] priv_line_i,
    output logic                irq_o,
    output logic                sgi_valid_o,
    output logic [SGI_ID_W-1:0] sgi_id_o,
    output logic [NUM_CPUS-1:0] sgi_targets_o
);

    localparam int ID_W       = $clog2(NUM_IDS);
    localparam int PID_W      = $clog2(PRIV_IDS);
    localparam int TRIG_WORDS = (2 * PRIV_IDS) / 32;

    typedef struct packed {
        logic [NUM_CPUS-1:0] targets;
        logic [SGI_ID_W-1:0] id;
    } sgi_t;

    logic                  ctrl_on_q;
    logic [NUM_IDS-1:0]    en_q;
    logic [NUM_IDS-1:0]    act_q;
    logic [2*PRIV_IDS-1:0] trig_q;
    logic [31:0]           rdata_q;
    logic                  sgi_valid_q;
    sgi_t                  sgi_q;

    logic [PRIV_IDS-1:0]   priv_pend;
    logic [NUM_IDS-1:0]    pend_all;
    logic [NUM_IDS-1:0]    cand;
    logic                  found;
    logic [ID_W-1:0]       pick_id;

    logic [ID_W-1:0]       wid;
    logic                  id_ok;
    logic                  rd_claim;
    logic                  grant;
    logic                  wr_en, wr_dis, wr_done;
    logic [31:0]           trig_rd;
    logic                  trig_hit;

    assign wid      = bus_wdata_i[ID_W-1:0];
    assign id_ok    = (bus_wdata_i >> ID_W) == 32'd0;
    assign wr_en    = bus_wr_i && bus_addr_i == OFS_EN   && id_ok;
    assign wr_dis   = bus_wr_i && bus_addr_i == OFS_DIS  && id_ok;
    assign wr_done  = bus_wr_i && bus_addr_i == OFS_DONE && id_ok;
    assign rd_claim = bus_rd_i && bus_addr_i == OFS_CLAIM;
    assign grant    = rd_claim && ctrl_on_q && found;

    cirq_priv_sense #(.PRIV_IDS(PRIV_IDS)) u_sense (
        .clk         (clk),
        .rst         (rst),
        .line_i      (priv_line_i),
        .cfg_i       (trig_q),
        .ack_valid_i (grant && (pick_id < ID_W'(PRIV_IDS))),
        .ack_id_i    (pick_id[PID_W-1:0]),
        .pend_o      (priv_pend)
    );

    assign pend_all = {shared_pend_i, priv_pend};
    assign cand     = pend_all & en_q & ~act_q;

    cirq_pick #(.NUM_IDS(NUM_IDS)) u_pick (
        .cand_i  (cand),
        .found_o (found),
        .id_o    (pick_id)
    );

    assign irq_o = ctrl_on_q && found;

    always_comb begin
        trig_rd  = '0;
        trig_hit = 1'b0;
        for (int k = 0; k < TRIG_WORDS; k++) begin
            if (bus_addr_i == OFS_TRIG + 12'(4 * k)) begin
                trig_rd  = trig_q[32*k +: 32];
                trig_hit = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_on_q <= 1'b0;
            en_q      <= '0;
            act_q     <= '0;
            trig_q    <= '0;
        end else begin
            if (bus_wr_i && bus_addr_i == OFS_CTRL)
                ctrl_on_q <= bus_wdata_i[0];
            if (bus_wr_i && trig_hit) begin
                for (int k = 0; k < TRIG_WORDS; k++)
                    if (bus_addr_i == OFS_TRIG + 12'(4 * k))
                        trig_q[32*k +: 32] <= bus_wdata_i;
            end
            if (wr_en)
                en_q[wid] <= 1'b1;
            if (wr_dis)
                en_q[wid] <= 1'b0;
            if (wr_done)
                act_q[wid] <= 1'b0;
            if (grant)
                act_q[pick_id] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (bus_rd_i) begin
            if (bus_addr_i == OFS_CTRL)
                rdata_q <= {31'd0, ctrl_on_q};
            else if (bus_addr_i == OFS_CLAIM)
                rdata_q <= grant ? 32'(pick_id) : NO_CLAIM;
            else if (trig_hit)
                rdata_q <= trig_rd;
            else
                rdata_q <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sgi_valid_q <= 1'b0;
            sgi_q       <= '0;
        end else begin
            sgi_valid_q <= bus_wr_i && bus_addr_i == OFS_SGI;
            if (bus_wr_i && bus_addr_i == OFS_SGI) begin
                sgi_q.id      <= bus_wdata_i[SGI_ID_W-1:0];
                sgi_q.targets <= bus_wdata_i[8 +: NUM_CPUS];
            end
        end
    end

    assign bus_rdata_o   = rdata_q;
    assign sgi_valid_o   = sgi_valid_q;
    assign sgi_id_o      = sgi_q.id;
    assign sgi_targets_o = sgi_q.targets;

    // R5: a claimed id is in service from the next cycle
    assert_claim_activates_R5: assert property (@(posedge clk) disable iff (rst)
        (grant && !wr_done) |=> act_q[$past(pick_id)]);

    // R5: a completion write takes the id out of service
    assert_done_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_done && !grant) |=> !act_q[$past(wid)]);

    // R6: a claim read with nothing to give returns the reserved code
    assert_empty_claim_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_claim && !grant) |=> bus_rdata_o == NO_CLAIM);

    // R7: a request always has an enabled pending source behind it
    assert_irq_has_source_R7: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ((pend_all & en_q) != '0));

    // R8: the send pulse follows a write to the send offset
    assert_sgi_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        sgi_valid_o |-> $past(bus_wr_i && bus_addr_i == OFS_SGI));

endmodule

// File: tb/cpu_irq_port_test.sv
module cpu_irq_port_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [223:0] shared_pend = '0;
    logic [31:0]  priv_line = '0;
    logic         irq;
    logic         sgi_valid;
    logic [3:0]   sgi_id;
    logic [7:0]   sgi_targets;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cpu_irq_port uut (
        .clk           (clk),
        .rst           (rst),
        .bus_wr_i      (bus_wr),
        .bus_rd_i      (bus_rd),
        .bus_addr_i    (bus_addr),
        .bus_wdata_i   (bus_wdata),
        .bus_rdata_o   (bus_rdata),
        .shared_pend_i (shared_pend),
        .priv_line_i   (priv_line),
        .irq_o         (irq),
        .sgi_valid_o   (sgi_valid),
        .sgi_id_o      (sgi_id),
        .sgi_targets_o (sgi_targets)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic claim_expect(input string req, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(12'h06C, d);
        chk(req, d, exp);
    endtask

    task automatic test_reset();
        logic [31:0] d;
        chk("R1 irq", 32'(irq), 0);
        chk("R1 sgi_valid", 32'(sgi_valid), 0);
        chk("R1 rdata", bus_rdata, 0);
        bus_read(12'h000, d); chk("R1 control", d, 0);
        bus_read(12'h014, d); chk("R1 trig0", d, 0);
        bus_read(12'h018, d); chk("R1 trig1", d, 0);
        claim_expect("R6 empty claim after reset", 32'h3FF);
    endtask

    task automatic test_gate_and_claim();
        shared_pend[40-32] = 1'b1;
        bus_write(12'h0A0, 40);
        chk("R2 irq low while off", 32'(irq), 0);
        claim_expect("R2 claim while off", 32'h3FF);
        bus_write(12'h000, 32'h1);
        begin
            logic [31:0] d;
            bus_read(12'h000, d); chk("R2 control readback", d, 1);
        end
        chk("R7 irq on", 32'(irq), 1);
        claim_expect("R4 claim id 40", 40);
        chk("R5 irq drops while active", 32'(irq), 0);
        claim_expect("R5 not offered again", 32'h3FF);
        bus_write(12'h0B4, 40);
        chk("R5 irq back after completion", 32'(irq), 1);
        claim_expect("R11 shared id reclaimed", 40);
        bus_write(12'h0B4, 40);
        shared_pend[40-32] = 1'b0;
        @(negedge clk);
        chk("R11 irq follows shared vector", 32'(irq), 0);
    endtask

    task automatic test_priority();
        bus_write(12'h0A0, 5);
        bus_write(12'h0A0, 33);
        bus_write(12'h0A0, 200);
        shared_pend[33-32]  = 1'b1;
        shared_pend[200-32] = 1'b1;
        priv_line[5] = 1'b1;
        claim_expect("R4 lowest first (private 5)", 5);
        claim_expect("R4 next 33", 33);
        claim_expect("R4 next 200", 200);
        claim_expect("R6 all active", 32'h3FF);
        bus_write(12'h0B4, 5);
        bus_write(12'h0B4, 33);
        bus_write(12'h0B4, 200);
        bus_write(12'h0A4, 5);
        claim_expect("R3 disabled id skipped", 33);
        bus_write(12'h0B4, 33);
        bus_write(12'h0A4, 33);
        bus_write(12'h0A4, 200);
        shared_pend = '0;
        priv_line = '0;
        @(negedge clk);
        chk("R7 irq low when nothing enabled", 32'(irq), 0);
    endtask

    task automatic test_bad_id();
        priv_line[7] = 1'b1;
        bus_write(12'h0A0, 32'h0000_0107);
        chk("R3 stray-bit enable ignored (irq)", 32'(irq), 0);
        claim_expect("R3 stray-bit enable ignored", 32'h3FF);
        priv_line[7] = 1'b0;
    endtask

    task automatic test_triggers();
        logic [31:0] d;
        bus_write(12'h014, (32'd1 << 4) | (32'd2 << 6));
        bus_write(12'h018, (32'd3 << 2));
        bus_read(12'h014, d); chk("R9 trig0 readback", d, 32'h0000_0090);
        bus_read(12'h018, d); chk("R9 trig1 readback", d, 32'h0000_000C);
        bus_write(12'h0A0, 2);
        claim_expect("R10 level-low id 2 pending on low line", 2);
        bus_write(12'h0B4, 2);
        bus_write(12'h0A4, 2);
        bus_write(12'h0A0, 3);
        chk("R10 rising id idle", 32'(irq), 0);
        @(negedge clk); priv_line[3] = 1'b1;
        @(negedge clk); priv_line[3] = 1'b0;
        @(negedge clk);
        chk("R10 rising edge held", 32'(irq), 1);
        claim_expect("R10 claim rising id", 3);
        bus_write(12'h0B4, 3);
        claim_expect("R10 edge cleared by claim", 32'h3FF);
        bus_write(12'h0A0, 17);
        @(negedge clk); priv_line[17] = 1'b1;
        @(negedge clk);
        chk("R10 falling id ignores rise", 32'(irq), 0);
        priv_line[17] = 1'b0;
        @(negedge clk);
        claim_expect("R9 falling edge on id 17", 17);
        bus_write(12'h0B4, 17);
    endtask

    task automatic test_sgi();
        bus_write(12'h060, 32'h00FF_A50C);
        chk("R8 valid pulse", 32'(sgi_valid), 1);
        chk("R8 id field", 32'(sgi_id), 32'hC);
        chk("R8 target field", 32'(sgi_targets), 32'hA5);
        @(negedge clk);
        chk("R8 pulse one cycle", 32'(sgi_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_gate_and_claim();
        test_priority();
        test_bad_id();
        test_triggers();
        test_sgi();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule